// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block chooses which physical frame to evict when memory is full, using a second-chance (clock) policy. It keeps one reference bit for each frame. Every access reported on the use port sets the bit of that frame. A circular hand pointer walks the frames in increasing order and wraps from the last frame to frame 0.

When a victim is requested, the hand looks at one frame per clock cycle. If the frame's bit is set, the hand clears it and moves on. It stops at the first frame whose bit is clear. That frame becomes the victim, and its bit is set again because the frame is about to be refilled. The hand is left pointing at the frame after the victim.

A parameter can enable a second, leading hand. This hand sits a fixed number of frames ahead of the evicting hand and clears reference bits while the scan runs, so that pages age faster.

The victim request is a valid/ready handshake: `req_ready` is high only while the selector is idle. The result is also a valid/ready handshake: `victim_valid` and `victim_frame` stay unchanged until the consumer raises `victim_ready`. The use port is a plain strobe with no back-pressure.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every reference bit is 0, the hand points at frame 0, `req_ready` is 1 and `victim_valid` is 0.
- R2: A cycle with `use_valid` high sets the reference bit of frame `use_frame`. The setting takes effect at the next clock edge.
- R3: During a scan, the hand examines one frame per cycle, in increasing frame order, wrapping from NUM_FRAMES-1 to 0. A frame whose bit is 1 has that bit cleared and is skipped.
- R4: The victim is the first frame examined whose bit is 0. After the victim is reported, the hand points at the frame after the victim, and the victim's bit is 1.
- R5: Take the edge that accepts a request as cycle 0. If k frames with set bits are skipped, `victim_valid` rises k+1 cycles later. So the victim is known within NUM_FRAMES+1 cycles, even when every bit starts at 1.
- R6: `victim_valid` and `victim_frame` hold steady until `victim_ready` is high. `req_ready` is 0 from the edge that accepts a request until the edge where the victim is taken, so any request in that window is ignored.
- R7: Suppose a use update and a scan clear hit the same frame in the same cycle. The use update wins, and that frame's bit stays 1.
- R8: When LEAD_DIST is greater than 0, each scan cycle also clears the bit of frame (hand + LEAD_DIST) mod NUM_FRAMES. A use update or a refill of that same frame in that same cycle still wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| use_valid | input | 1 | Access strobe for the frame on `use_frame` |
| use_frame | input | IDX_W | Index of the frame being accessed |
| req_valid | input | 1 | Request for an eviction victim |
| req_ready | output | 1 | High while the selector is idle and can accept a request |
| victim_valid | output | 1 | The victim index is available |
| victim_ready | input | 1 | The consumer takes the victim |
| victim_frame | output | IDX_W | Index of the selected victim frame |

## Verification
The assertions assume that `use_frame` is always below NUM_FRAMES. They also assume that LEAD_DIST is less than NUM_FRAMES, so the leading hand never lands on the evicting hand. The stimulus keeps within both limits: it uses eight frames and leading distances of 0 and 4.

Requests are raised only while `req_ready` is high. Use strobes are driven on the falling edge, so each one lines up with a known scan cycle. This is how the bench forces the same-cycle conflict between a use update and a scan clear on one chosen frame.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } scan_state_e;
endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  use_en,
  input  logic [IDX_W-1:0]      use_idx,
  input  logic                  fill_en,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic                  clr_en,
  input  logic [IDX_W-1:0]      clr_idx,
  input  logic                  age_en,
  input  logic [IDX_W-1:0]      age_idx,
  output logic [NUM_FRAMES-1:0] bits
);
  logic [NUM_FRAMES-1:0] bits_nxt;

  // Clears first, then sets: any set in the same cycle overrides a clear.
  always_comb begin
    bits_nxt = bits;
    if (clr_en)  bits_nxt[clr_idx]  = 1'b0;
    if (age_en)  bits_nxt[age_idx]  = 1'b0;
    if (use_en)  bits_nxt[use_idx]  = 1'b1;
    if (fill_en) bits_nxt[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else        bits <= bits_nxt;
  end

  a_r2_use_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    use_en |=> bits[$past(use_idx)]);

  a_r3_scan_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(use_en && use_idx == clr_idx)) |=> !bits[$past(clr_idx)]);

  a_r7_use_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && use_en && use_idx == clr_idx) |=> bits[$past(clr_idx)]);

  a_r4_refill_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> bits[$past(fill_idx)]);
endmodule

// File: rtl/clock_hand.sv
module clock_hand
  import clock_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = $clog2(NUM_FRAMES),
  parameter int LEAD_DIST  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  output logic                  victim_valid,
  input  logic                  victim_ready,
  output logic [IDX_W-1:0]      victim_frame,
  input  logic [NUM_FRAMES-1:0] bits,
  output logic                  clr_en,
  output logic [IDX_W-1:0]      clr_idx,
  output logic                  fill_en,
  output logic [IDX_W-1:0]      fill_idx,
  output logic                  age_en,
  output logic [IDX_W-1:0]      age_idx
);
  localparam int CNT_W = IDX_W + 2;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  scan_state_e      state;
  logic [IDX_W-1:0] hand;
  logic [IDX_W-1:0] hand_nxt;
  logic [IDX_W-1:0] victim_q;
  logic             scanning;
  logic             cur_set;

  assign scanning  = (state == ST_SCAN);
  assign cur_set   = bits[hand];
  assign hand_nxt  = (hand == LAST) ? '0 : hand + 1'b1;

  assign clr_en    = scanning && cur_set;
  assign clr_idx   = hand;
  assign fill_en   = scanning && !cur_set;
  assign fill_idx  = hand;

  assign req_ready    = (state == ST_IDLE);
  assign victim_valid = (state == ST_HOLD);
  assign victim_frame = victim_q;

  generate
    if (LEAD_DIST > 0) begin : g_lead
      assign age_en  = scanning;
      assign age_idx = IDX_W'((int'(hand) + LEAD_DIST) % NUM_FRAMES);
    end else begin : g_single
      assign age_en  = 1'b0;
      assign age_idx = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      hand     <= '0;
      victim_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) state <= ST_SCAN;
        ST_SCAN: begin
          hand <= hand_nxt;
          if (!cur_set) begin
            victim_q <= hand;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: if (victim_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Scan-length counter used only to bound the search window.
  logic [CNT_W-1:0] scan_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)        scan_cnt <= '0;
    else if (scanning) scan_cnt <= scan_cnt + 1'b1;
    else               scan_cnt <= '0;
  end

  a_r5_scan_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    scanning |-> (int'(scan_cnt) <= NUM_FRAMES));

  a_r6_victim_held: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && !victim_ready) |=> (victim_valid && $stable(victim_frame)));

  a_r3_set_bit_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && cur_set) |=> (scanning && !victim_valid));

  a_r4_victim_had_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(victim_valid) |-> !$past(cur_set));

  a_r6_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning || victim_valid) |-> !req_ready);
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int LEAD_DIST  = 0,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_valid,
  input  logic [IDX_W-1:0] use_frame,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             victim_valid,
  input  logic             victim_ready,
  output logic [IDX_W-1:0] victim_frame
);
  logic [NUM_FRAMES-1:0] ref_bits;
  logic                  clr_en, fill_en, age_en;
  logic [IDX_W-1:0]      clr_idx, fill_idx, age_idx;

  clock_hand #(
    .NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W), .LEAD_DIST(LEAD_DIST)
  ) u_hand (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .victim_valid(victim_valid), .victim_ready(victim_ready),
    .victim_frame(victim_frame), .bits(ref_bits),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .fill_en(fill_en), .fill_idx(fill_idx),
    .age_en(age_en), .age_idx(age_idx)
  );

  ref_bit_array #(
    .NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)
  ) u_bits (
    .clk(clk), .rst_n(rst_n),
    .use_en(use_valid), .use_idx(use_frame),
    .fill_en(fill_en), .fill_idx(fill_idx),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .age_en(age_en), .age_idx(age_idx),
    .bits(ref_bits)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_ready && !victim_valid));
endmodule

// File: tb/clock_victim_sel_test.sv
module clock_victim_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          use_valid = 1'b0, req_valid = 1'b0, victim_ready = 1'b0;
  logic [IW-1:0] use_frame = '0;
  logic          req_ready, victim_valid;
  logic [IW-1:0] victim_frame;

  logic          b_use_valid = 1'b0, b_req_valid = 1'b0, b_victim_ready = 1'b0;
  logic [IW-1:0] b_use_frame = '0;
  logic          b_req_ready, b_victim_valid;
  logic [IW-1:0] b_victim_frame;

  clock_victim_sel #(.NUM_FRAMES(N), .LEAD_DIST(0)) uut (
    .clk(clk), .rst_n(rst_n), .use_valid(use_valid), .use_frame(use_frame),
    .req_valid(req_valid), .req_ready(req_ready),
    .victim_valid(victim_valid), .victim_ready(victim_ready),
    .victim_frame(victim_frame)
  );

  clock_victim_sel #(.NUM_FRAMES(N), .LEAD_DIST(4)) uut_lead (
    .clk(clk), .rst_n(rst_n), .use_valid(b_use_valid), .use_frame(b_use_frame),
    .req_valid(b_req_valid), .req_ready(b_req_ready),
    .victim_valid(b_victim_valid), .victim_ready(b_victim_ready),
    .victim_frame(b_victim_frame)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic touch(input int f);
    use_valid = 1'b1;
    use_frame = IW'(f);
    @(negedge clk);
    use_valid = 1'b0;
  endtask

  task automatic fetch(output int frame, output int lat);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!victim_valid && lat < 4*N) begin
      lat++;
      @(negedge clk);
    end
    frame = int'(victim_frame);
    victim_ready = 1'b1;
    @(negedge clk);
    victim_ready = 1'b0;
  endtask

  task automatic t_reset_state();
    check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    check(victim_valid == 1'b0, "R1 victim_valid", int'(victim_valid), 0);
  endtask

  task automatic t_first_victims();
    int f, l;
    fetch(f, l);
    check(f == 0, "R1 first victim at hand 0", f, 0);
    check(l == 1, "R5 latency with no set bits", l, 1);
    fetch(f, l);
    check(f == 1, "R4 hand moved past victim", f, 1);
  endtask

  task automatic t_skip_used();
    int f, l;
    touch(2);
    touch(3);
    fetch(f, l);
    check(f == 4, "R2 R3 used frames skipped", f, 4);
    check(l == 3, "R5 latency two skips", l, 3);
  endtask

  task automatic t_all_set_wrap();
    int f, l;
    for (int i = 0; i < N; i++) touch(i);
    fetch(f, l);
    check(f == 5, "R3 wrap victim returns to start", f, 5);
    check(l == N + 1, "R5 full wrap latency", l, N + 1);
  endtask

  task automatic t_backpressure();
    int f;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!victim_valid) @(negedge clk);
    f = int'(victim_frame);
    check(f == 6, "R4 victim after wrap", f, 6);
    req_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!(victim_valid && int'(victim_frame) == f && !req_ready))
        check(1'b0, "R6 victim held under backpressure", int'(victim_frame), f);
    end
    check(victim_valid && int'(victim_frame) == f, "R6 still held", int'(victim_frame), f);
    check(req_ready == 1'b0, "R6 request ignored while busy", int'(req_ready), 0);
    req_valid = 1'b0;
    victim_ready = 1'b1;
    @(negedge clk);
    victim_ready = 1'b0;
    check(req_ready == 1'b1 && !victim_valid, "R6 idle after take", int'(req_ready), 1);
  endtask

  task automatic t_collision();
    int f, l;
    int exp_seq[4] = '{2, 3, 4, 0};
    touch(7);
    touch(0);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    use_valid = 1'b1;
    use_frame = 3'd7;
    @(negedge clk);
    use_valid = 1'b0;
    while (!victim_valid) @(negedge clk);
    f = int'(victim_frame);
    victim_ready = 1'b1;
    @(negedge clk);
    victim_ready = 1'b0;
    check(f == 1, "R7 collision scan victim", f, 1);
    for (int i = 0; i < 4; i++) begin
      fetch(f, l);
      check(f == exp_seq[i], "R7 use kept bit set", f, exp_seq[i]);
    end
  endtask

  task automatic t_lead_hand();
    int l;
    for (int i = 0; i < N; i++) begin
      b_use_valid = 1'b1;
      b_use_frame = IW'(i);
      @(negedge clk);
    end
    b_use_valid = 1'b0;
    b_req_valid = 1'b1;
    @(negedge clk);
    b_req_valid = 1'b0;
    l = 0;
    while (!b_victim_valid && l < 4*N) begin
      l++;
      @(negedge clk);
    end
    check(int'(b_victim_frame) == 4, "R8 leading hand aged frame 4", int'(b_victim_frame), 4);
    check(l == 5, "R8 leading hand latency", l, 5);
    b_victim_ready = 1'b1;
    @(negedge clk);
    b_victim_ready = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_first_victims();
    t_skip_used();
    t_all_set_wrap();
    t_backpressure();
    t_collision();
    t_lead_hand();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule